// File: doc/BRIEF.md
# Peripheral Function Power-State Controller

This block holds the power-management state of one bus peripheral function. It tracks four conditions: an uninitialised full-power state, a configured full-power state, a software-requested low-power state in which power and clock stay present, and a powered-off state that is entered whenever main supply is lost. Software moves the function between states by writing a small register set through a configuration write port. A bus reset input and a main-power-good input drive the hardware-initiated transitions.

On the way out of the software low-power state, the block runs an internal soft reset of a fixed length. During that reset it holds the bus output drivers off and refuses configuration accesses. On the way out of the powered-off state, a bus reset is needed, and that reset restores the hardware defaults. A two-bit wake-event context (enable and status) survives both paths. On the powered-off path it survives only if auxiliary power was present for the whole outage.

Top module: `pm_state_ctrl`

## Requirements
- R1: While `bus_rst_n` is low and main power is good, the next edge puts the function in D0-uninitialised. In that state `pstate_rd`=00, `func_en`=0, `soft_rst`=0, `drv_en`=1 and `cfg_accept`=1. A reset taken while `aux_pwr_ok` is low also clears the wake context to `pme_en`=0 and `pme_sts`=0.
- R2: In either D0 state, a write to address 1 sets or clears the function enable from bit 0 of the data. Bit 0 = 1 moves D0-uninitialised to D0-active (`func_en`=1). Bit 0 = 0 returns the function to D0-uninitialised.
- R3: Address 0, bits [1:0], is the power-state field. Code 00 means D0 and code 11 means D3. Writing 11 from a D0 state enters the low-power state, reads back as 11 and clears `func_en`. Writing 01 or 10 leaves the state unchanged.
- R4: In the low-power state, only a write of 00 to address 0 changes the state. `cfg_accept` and `drv_en` stay high in this state, and enable writes to address 1 are ignored.
- R5: Writing 00 in the low-power state starts a soft reset without any bus reset. `soft_rst` is high for exactly `SRST_CYC` cycles (default 16), with `drv_en`=0 and `cfg_accept`=0. The function then reaches D0-uninitialised with drivers enabled.
- R6: Address 2 holds the wake context. Bit 0 is the wake enable. Bit 1 is the wake status, and writing 1 to it clears the status. A `wake_evt` pulse sets the status, and a set wins over a clear in the same cycle. `pme_wake` equals enable AND status.
- R7: The wake context is left unchanged by entering the low-power state and by the whole soft reset.
- R8: When `main_pwr_ok` is low, the next edge enters the powered-off state, even if a power-state write arrives in the same cycle. In this state `pstate_rd`=11, and `drv_en`, `cfg_accept` and `func_en` are all 0.
- R9: The powered-off state is held after main power returns, until a bus reset. Configuration writes are ignored in this state.
- R10: With `PME_COLD`=1, a bus reset that ends a power-off keeps the wake context if auxiliary power was present throughout the outage. If main and auxiliary power were both low at any edge, the next bus reset clears the context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous |
| main_pwr_ok | input | 1 | Main supply good |
| aux_pwr_ok | input | 1 | Auxiliary supply good |
| wake_evt | input | 1 | Wake event from function logic |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 power state, 1 control, 2 wake context |
| cfg_wdata | input | DATA_W | Write data |
| pstate_rd | output | 2 | Power-state field as read by software |
| func_en | output | 1 | Function configured and active |
| soft_rst | output | 1 | Internal warm reset in progress |
| drv_en | output | 1 | Bus output drivers enabled |
| cfg_accept | output | 1 | Configuration accesses accepted |
| pme_en | output | 1 | Wake enable |
| pme_sts | output | 1 | Wake status |
| pme_wake | output | 1 | Wake request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a wake event and a software clear of the wake status. The bench drives both in one cycle while in the low-power state and expects the status to remain set. The second pair is a D0 write in the low-power state and a loss of main power. The bench presents both on the same edge and expects the powered-off state, with no soft reset started and the wake context untouched.

// File: rtl/pm_pkg.sv
// Package: shared state encoding and register map for the power-state controller.
// Assumes a 2-bit register address; the power-state field codes are fixed by software.
package pm_pkg;
    typedef enum logic [2:0] {
        PS_D0U  = 3'd0,
        PS_D0A  = 3'd1,
        PS_D3H  = 3'd2,
        PS_SRST = 3'd3,
        PS_D3C  = 3'd4
    } pm_state_e;

    localparam logic [1:0] PSF_D0 = 2'b00;
    localparam logic [1:0] PSF_D3 = 2'b11;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] REG_PSTATE = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_PME    = 2'd2;
endpackage

// File: rtl/pm_cfg_decode.sv
// Module: pm_cfg_decode
// Turns a raw configuration write into per-register write strobes and fields.
// Assumes the FSM's accept signal already reflects power and state; writes are
// also dropped during bus reset and in any cycle with main power low.
module pm_cfg_decode
    import pm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic              main_pwr_ok,
    input  logic              cfg_accept,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              wr_pstate,
    output logic              wr_ctrl,
    output logic              wr_pme,
    output logic [1:0]        pstate_val,
    output logic              ctrl_en_val,
    output logic              pme_en_val,
    output logic              pme_clr_val
);
    logic wr_ok;

    // Qualify the write with access acceptance and live power.
    always_comb begin
        wr_ok       = cfg_wr && cfg_accept && bus_rst_n && main_pwr_ok;
        wr_pstate   = wr_ok && (cfg_addr == REG_PSTATE);
        wr_ctrl     = wr_ok && (cfg_addr == REG_CTRL);
        wr_pme      = wr_ok && (cfg_addr == REG_PME);
        pstate_val  = cfg_wdata[1:0];
        ctrl_en_val = cfg_wdata[0];
        pme_en_val  = cfg_wdata[0];
        pme_clr_val = cfg_wdata[1];
    end

    // R9: no register strobe may escape while accesses are refused.
    a_r9_no_write_closed: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !cfg_accept |-> !(wr_pstate || wr_ctrl || wr_pme));
endmodule

// File: rtl/pm_fsm.sv
// Module: pm_fsm
// Power-state sequencer: D0 uninitialised/active, D3hot, soft reset and D3cold.
// Assumes main power loss outranks bus reset, which outranks software writes.
// The soft-reset length is SRST_CYC cycles counted by a down-counter.
module pm_fsm
    import pm_pkg::*;
#(
    parameter int SRST_CYC = 16
) (
    input  logic      clk,
    input  logic      bus_rst_n,
    input  logic      main_pwr_ok,
    input  logic      wr_pstate,
    input  logic      wr_ctrl,
    input  logic [1:0] pstate_val,
    input  logic      ctrl_en_val,
    output pm_state_e state
);
    localparam int CNT_W = (SRST_CYC > 1) ? $clog2(SRST_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // State register with power loss first, then bus reset, then software.
    always_ff @(posedge clk) begin
        if (!main_pwr_ok) begin
            state <= PS_D3C;
            cnt   <= '0;
        end else if (!bus_rst_n) begin
            state <= PS_D0U;
            cnt   <= '0;
        end else begin
            case (state)
                PS_D0U, PS_D0A: begin
                    if (wr_pstate && pstate_val == PSF_D3) begin
                        state <= PS_D3H;
                    end else if (wr_ctrl) begin
                        state <= ctrl_en_val ? PS_D0A : PS_D0U;
                    end
                end
                PS_D3H: begin
                    if (wr_pstate && pstate_val == PSF_D0) begin
                        state <= PS_SRST;
                        cnt   <= CNT_LOAD;
                    end
                end
                PS_SRST: begin
                    if (cnt == '0) begin
                        state <= PS_D0U;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= PS_D3C;
            endcase
        end
    end

    // Checker counter: cycles already spent in the current soft reset.
    logic [CNT_W:0] srst_seen;
    always_ff @(posedge clk) begin
        if (!bus_rst_n || state != PS_SRST) srst_seen <= '0;
        else                                srst_seen <= srst_seen + 1'b1;
    end

    // R5: the soft reset ends only after exactly SRST_CYC cycles.
    a_r5_srst_len: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (state == PS_SRST && main_pwr_ok && $past(state) == PS_SRST && cnt == '0)
            |-> (srst_seen == (CNT_W+1)'(SRST_CYC - 1)));
    // R4: D3hot is left only by a D0 write or power loss.
    a_r4_d3_exit: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (state == PS_D3H && main_pwr_ok && !(wr_pstate && pstate_val == PSF_D0))
            |=> (state == PS_D3H));
    // R8: main power loss forces D3cold on the next edge.
    a_r8_cold_entry: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !main_pwr_ok |=> (state == PS_D3C));
    // R9: D3cold is held until a bus reset.
    a_r9_cold_hold: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (state == PS_D3C) |=> (state == PS_D3C));
endmodule

// File: rtl/pm_pme_ctx.sv
// Module: pm_pme_ctx
// Wake-event context (enable and status) that is retained across low-power states.
// Assumes it sits on auxiliary power. A bus reset clears it when aux is absent,
// when aux was lost during an outage, or when PME_COLD is 0.
module pm_pme_ctx #(
    parameter bit PME_COLD = 1'b1
) (
    input  logic clk,
    input  logic bus_rst_n,
    input  logic main_pwr_ok,
    input  logic aux_pwr_ok,
    input  logic wake_evt,
    input  logic wr_pme,
    input  logic pme_en_val,
    input  logic pme_clr_val,
    output logic pme_en,
    output logic pme_sts
);
    logic ctx_lost;
    logic any_pwr;

    // Any supply able to keep this register alive.
    always_comb any_pwr = main_pwr_ok || aux_pwr_ok;

    // Context register: conditional clear on reset, else write, set and W1C.
    always_ff @(posedge clk) begin
        if (!bus_rst_n && (!aux_pwr_ok || ctx_lost || !PME_COLD)) begin
            pme_en   <= 1'b0;
            pme_sts  <= 1'b0;
            ctx_lost <= 1'b0;
        end else begin
            if (!bus_rst_n)  ctx_lost <= 1'b0;
            else if (!any_pwr) ctx_lost <= 1'b1;
            if (wr_pme) pme_en <= pme_en_val;
            if (wake_evt && any_pwr)         pme_sts <= 1'b1;
            else if (wr_pme && pme_clr_val)  pme_sts <= 1'b0;
        end
    end

    // R7: without a write or wake event the context does not move.
    a_r7_pme_hold: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (!wr_pme && !wake_evt) |=> $stable({pme_en, pme_sts}));
    // R6: a powered wake event always leaves the status set.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (wake_evt && any_pwr) |=> pme_sts);
endmodule

// File: rtl/pm_state_ctrl.sv
// Module: pm_state_ctrl (top)
// Power-state controller for one bus peripheral function. Wires the write
// decoder, the state sequencer and the wake context together, and derives
// the port-level status from the sequencer state.
// Assumes all inputs are synchronous to clk.
module pm_state_ctrl
    import pm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SRST_CYC = 16,
    parameter bit PME_COLD = 1'b1
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic              main_pwr_ok,
    input  logic              aux_pwr_ok,
    input  logic              wake_evt,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [1:0]        pstate_rd,
    output logic              func_en,
    output logic              soft_rst,
    output logic              drv_en,
    output logic              cfg_accept,
    output logic              pme_en,
    output logic              pme_sts,
    output logic              pme_wake
);
    pm_state_e state;
    logic       wr_pstate, wr_ctrl, wr_pme;
    logic [1:0] pstate_val;
    logic       ctrl_en_val, pme_en_val, pme_clr_val;

    pm_cfg_decode #(.DATA_W(DATA_W)) u_dec (
        .clk(clk), .bus_rst_n(bus_rst_n), .main_pwr_ok(main_pwr_ok),
        .cfg_accept(cfg_accept), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wr_pstate(wr_pstate), .wr_ctrl(wr_ctrl),
        .wr_pme(wr_pme), .pstate_val(pstate_val), .ctrl_en_val(ctrl_en_val),
        .pme_en_val(pme_en_val), .pme_clr_val(pme_clr_val)
    );

    pm_fsm #(.SRST_CYC(SRST_CYC)) u_fsm (
        .clk(clk), .bus_rst_n(bus_rst_n), .main_pwr_ok(main_pwr_ok),
        .wr_pstate(wr_pstate), .wr_ctrl(wr_ctrl), .pstate_val(pstate_val),
        .ctrl_en_val(ctrl_en_val), .state(state)
    );

    pm_pme_ctx #(.PME_COLD(PME_COLD)) u_pme (
        .clk(clk), .bus_rst_n(bus_rst_n), .main_pwr_ok(main_pwr_ok),
        .aux_pwr_ok(aux_pwr_ok), .wake_evt(wake_evt), .wr_pme(wr_pme),
        .pme_en_val(pme_en_val), .pme_clr_val(pme_clr_val),
        .pme_en(pme_en), .pme_sts(pme_sts)
    );

    // Port status decoded from the sequencer state.
    always_comb begin
        pstate_rd  = (state == PS_D3H || state == PS_D3C) ? PSF_D3 : PSF_D0;
        func_en    = (state == PS_D0A);
        soft_rst   = (state == PS_SRST);
        drv_en     = (state == PS_D0U) || (state == PS_D0A) || (state == PS_D3H);
        cfg_accept = drv_en;
        pme_wake   = pme_en && pme_sts;
    end

    // R5: drivers are never enabled while the soft reset runs.
    a_r5_drv_off: assert property (@(posedge clk) disable iff (!bus_rst_n)
        soft_rst |-> (!drv_en && !cfg_accept));
endmodule

// File: tb/pm_state_ctrl_tb.sv
module pm_state_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SRST_CYC   = 16;

    // Expected status {pstate_rd, func_en, soft_rst, drv_en, cfg_accept}
    localparam logic [5:0] XU = 6'b00_0011;
    localparam logic [5:0] XA = 6'b00_1011;
    localparam logic [5:0] XH = 6'b11_0011;
    localparam logic [5:0] XS = 6'b00_0100;
    localparam logic [5:0] XC = 6'b11_0000;

    // Row: {rst_n,main,aux,wake,wr}, addr, wdata, status, {pme_en,pme_sts}, req
    localparam int NV = 29;
    localparam logic [26:0] VEC [NV] = '{
        {5'b11101, 2'd2, 8'h01, XU, 2'b10, 4'd6},  // R6 enable wake
        {5'b11110, 2'd0, 8'h00, XU, 2'b11, 4'd6},  // R6 wake sets status
        {5'b10100, 2'd0, 8'h00, XC, 2'b11, 4'd8},  // R8 main power lost
        {5'b11100, 2'd0, 8'h00, XC, 2'b11, 4'd9},  // R9 power back, no reset
        {5'b11101, 2'd1, 8'h01, XC, 2'b11, 4'd9},  // R9 write ignored
        {5'b01100, 2'd0, 8'h00, XU, 2'b11, 4'd10}, // R10 reset keeps context
        {5'b10000, 2'd0, 8'h00, XC, 2'b11, 4'd10}, // R10 aux lost too
        {5'b11100, 2'd0, 8'h00, XC, 2'b11, 4'd10}, // R10 power back
        {5'b01100, 2'd0, 8'h00, XU, 2'b00, 4'd10}, // R10 reset clears context
        {5'b11101, 2'd1, 8'h01, XA, 2'b00, 4'd2},  // R2 enable
        {5'b01100, 2'd0, 8'h00, XU, 2'b00, 4'd1},  // R1 reset clears enable
        {5'b11101, 2'd1, 8'h01, XA, 2'b00, 4'd2},  // R2 enable again
        {5'b11101, 2'd2, 8'h01, XA, 2'b10, 4'd6},  // R6 set wake enable
        {5'b11101, 2'd0, 8'h02, XA, 2'b10, 4'd3},  // R3 code 10 ignored
        {5'b11101, 2'd0, 8'h01, XA, 2'b10, 4'd3},  // R3 code 01 ignored
        {5'b11101, 2'd1, 8'h00, XU, 2'b10, 4'd2},  // R2 disable
        {5'b11101, 2'd1, 8'h01, XA, 2'b10, 4'd2},  // R2 re-enable
        {5'b11101, 2'd0, 8'h03, XH, 2'b10, 4'd3},  // R3 enter D3hot, R7 context kept
        {5'b11101, 2'd1, 8'h01, XH, 2'b10, 4'd4},  // R4 enable write ignored
        {5'b11101, 2'd0, 8'h02, XH, 2'b10, 4'd4},  // R4 code 10 ignored
        {5'b11101, 2'd0, 8'h01, XH, 2'b10, 4'd4},  // R4 code 01 ignored
        {5'b11110, 2'd0, 8'h00, XH, 2'b11, 4'd6},  // R6 wake in D3hot
        {5'b11111, 2'd2, 8'h03, XH, 2'b11, 4'd6},  // R6 set wins over clear
        {5'b11101, 2'd2, 8'h03, XH, 2'b10, 4'd6},  // R6 clear status
        {5'b10101, 2'd0, 8'h00, XC, 2'b10, 4'd8},  // R8 power loss beats D0 write
        {5'b11100, 2'd0, 8'h00, XC, 2'b10, 4'd9},  // R9 still cold
        {5'b01100, 2'd0, 8'h00, XU, 2'b10, 4'd10}, // R10 reset keeps context
        {5'b11101, 2'd0, 8'h03, XH, 2'b10, 4'd3},  // R3 enter D3hot
        {5'b11110, 2'd0, 8'h00, XH, 2'b11, 4'd6}   // R6 wake
    };

    logic       clk = 1'b0;
    logic       bus_rst_n, main_pwr_ok, aux_pwr_ok, wake_evt, cfg_wr;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [1:0] pstate_rd;
    logic       func_en, soft_rst, drv_en, cfg_accept, pme_en, pme_sts, pme_wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_state_ctrl #(.DATA_W(8), .SRST_CYC(SRST_CYC), .PME_COLD(1'b1)) u_dut (
        .clk(clk), .bus_rst_n(bus_rst_n), .main_pwr_ok(main_pwr_ok),
        .aux_pwr_ok(aux_pwr_ok), .wake_evt(wake_evt), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pstate_rd(pstate_rd),
        .func_en(func_en), .soft_rst(soft_rst), .drv_en(drv_en),
        .cfg_accept(cfg_accept), .pme_en(pme_en), .pme_sts(pme_sts),
        .pme_wake(pme_wake)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] observe();
        return {pstate_rd, func_en, soft_rst, drv_en, cfg_accept, pme_en, pme_sts};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bus_rst_n = 1'b0; main_pwr_ok = 1'b1; aux_pwr_ok = 1'b0;
        wake_evt = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        @(negedge clk);
        step(); step();
        // R1: reset state with aux absent
        check(1, observe(), {XU, 2'b00});
        check(1, {7'd0, pme_wake}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            {bus_rst_n, main_pwr_ok, aux_pwr_ok, wake_evt, cfg_wr} = VEC[i][26:22];
            cfg_addr  = VEC[i][21:20];
            cfg_wdata = VEC[i][19:12];
            step();
            check(int'(VEC[i][3:0]), observe(), VEC[i][11:4]);
        end

        // R6: wake request output with enable and status both set
        bus_rst_n = 1'b1; main_pwr_ok = 1'b1; aux_pwr_ok = 1'b1;
        wake_evt = 1'b0; cfg_wr = 1'b0;
        check(6, {7'd0, pme_wake}, 8'd1);

        // R5: D0 write from D3hot starts a soft reset of SRST_CYC cycles
        cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h00;
        step();
        cfg_wr = 1'b0;
        check(5, observe(), {XS, 2'b11});
        for (int k = 1; k < SRST_CYC; k++) begin
            step();
            check(5, observe(), {XS, 2'b11});
        end
        step();
        // R5 end of soft reset, R7 context retained
        check(5, observe(), {XU, 2'b11});
        check(7, {6'd0, pme_en, pme_sts}, 8'b11);

        // R2: function usable again after soft reset
        cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'h01;
        step();
        cfg_wr = 1'b0;
        check(2, observe(), {XA, 2'b11});

        finish_run();
    end
endmodule